// File: doc/BRIEF.md
# Vector Loop Issue Sequencer

This block sits between instruction decode and issue. It takes one decoded three-operand scalar instruction and expands it into a run of scalar micro-operations. The run has one micro-op for each element index from zero up to the current vector length minus one. Each operand is either the destination or one of the two sources, and each has its own vector/scalar flag. A vector operand moves to the next register on every element. A scalar operand keeps its base register for the whole run. When all three operands are scalar, the instruction goes through as a single micro-op.

Two length registers set the size of the run: a maximum vector length and a vector length. Both are written through a small CSR-style port. Every field holds the length minus one. The vector length is always clamped so that it never exceeds the maximum. A write is answered one cycle later with the value that now sits in the register, not the value it held before.

The controller has two states. `S_IDLE` accepts an instruction. `S_ISSUE` emits micro-ops. It has three transitions:
- ACCEPT (`S_IDLE` to `S_ISSUE`) happens when `in_valid` is high while idle.
- STEP (`S_ISSUE` to `S_ISSUE`) happens when a non-final micro-op is taken.
- DONE (`S_ISSUE` to `S_IDLE`) happens when the final micro-op is taken.

Top module: `vec_loop_sequencer`

## Requirements
- R1: The vector-length field never exceeds the maximum-length field.
  - A vector-length write above the maximum stores the maximum.
  - A maximum-length write below the current vector length lowers the vector length to the new maximum.
- R2: `csr_sel` picks the register: 0 is the maximum length and 1 is the vector length. Fields hold length minus one. `csr_rdata` is registered: one cycle after a request it shows the field selected by `csr_sel`, as it stands after any write in that request. A write therefore returns the new, clamped value.
- R3: After reset both fields are 0, so both lengths are 1. `in_ready` is 1 and `uop_valid` is 0.
- R4: Operand flags sit in `in_vec`: bit 0 is the destination, bit 1 is source 1 and bit 2 is source 2. For element i, a flagged operand uses base+i and an unflagged operand uses its base register.
- R5: The three operands step independently inside the same run, each according to its own flag.
- R6: When `in_vec` is 000, exactly one micro-op is issued. It has element index 0 and `uop_last` set.
- R7: Otherwise the run holds vector-length-field+1 micro-ops. `uop_elem` counts from 0, and `uop_last` is set only on the final one. The first micro-op is valid in the cycle after acceptance.
- R8: `in_ready` is low while a run is in progress. A waiting instruction is accepted only after the previous run's final micro-op has been taken.
- R9: While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value and the element counter does not advance.
- R10: Register indices are 7 bits and wrap modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Length register write strobe |
| csr_sel | input | 1 | 0 selects the maximum length, 1 selects the vector length |
| csr_wdata | input | LEN_W | Length minus one to write |
| csr_rdata | output | LEN_W | Registered field value after the request |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Sequencer idle and accepting |
| in_dst | input | 7 | Destination base register |
| in_src1 | input | 7 | Source 1 base register |
| in_src2 | input | 7 | Source 2 base register |
| in_vec | input | 3 | Vector flags: dst, src1, src2 |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Issue stage takes the micro-op |
| uop_dst | output | 7 | Destination register for this element |
| uop_src1 | output | 7 | Source 1 register for this element |
| uop_src2 | output | 7 | Source 2 register for this element |
| uop_elem | output | LEN_W | Element index |
| uop_last | output | 1 | Final element of the run |

## Verification
Two functions can land in the same cycle.

The first pair is the output stall and the end of a run. A randomised `uop_ready` pattern stalls the last micro-op of a run while a second instruction is already waiting on `in_valid`. The scoreboard judges this in three ways:
- The waiting instruction's micro-ops must appear strictly after the stalled final one.
- `in_ready` must stay low until that final micro-op has been taken.
- Every stalled cycle must show unchanged outputs.

The second pair is a maximum-length write that collides with a larger stored vector length. The write response and a follow-up read must both show the clamped value. The next run must have exactly that length.

// File: rtl/vls_pkg.sv
package vls_pkg;
    localparam int PHYS_REG_W = 7;
    localparam int NUM_OPERANDS = 3;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/vls_len_csr.sv
module vls_len_csr #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [LEN_W-1:0] wdata,
    output logic [LEN_W-1:0] rdata,
    output logic [LEN_W-1:0] maxlen_o,
    output logic [LEN_W-1:0] len_o
);
    logic [LEN_W-1:0] maxlen_q, maxlen_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic [LEN_W-1:0] rdata_q, rdata_d;

    always_comb begin
        maxlen_d = maxlen_q;
        len_d    = len_q;
        if (we && !sel) begin
            maxlen_d = wdata;
            len_d    = (len_q > wdata) ? wdata : len_q;
        end else if (we && sel) begin
            len_d = (wdata > maxlen_q) ? maxlen_q : wdata;
        end
        rdata_d = sel ? len_d : maxlen_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maxlen_q <= '0;
            len_q    <= '0;
            rdata_q  <= '0;
        end else begin
            maxlen_q <= maxlen_d;
            len_q    <= len_d;
            rdata_q  <= rdata_d;
        end
    end

    assign rdata    = rdata_q;
    assign maxlen_o = maxlen_q;
    assign len_o    = len_q;

    AST_LEN_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= maxlen_q); // R1
    AST_LEN_WRITE_RETURNS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> (rdata == len_q)); // R2
    AST_MAX_WRITE_RETURNS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel) |=> (rdata == $past(wdata))); // R2
endmodule

// File: rtl/vls_operand_step.sv
module vls_operand_step #(
    parameter int LEN_W = 5
) (
    input  logic [vls_pkg::PHYS_REG_W-1:0] base_i,
    input  logic                           vec_i,
    input  logic [LEN_W-1:0]               elem_i,
    output logic [vls_pkg::PHYS_REG_W-1:0] idx_o
);
    import vls_pkg::*;

    logic [PHYS_REG_W-1:0] offset;

    always_comb begin
        offset = vec_i ? PHYS_REG_W'(elem_i) : '0;
        idx_o  = base_i + offset;
    end
endmodule

// File: rtl/vls_loop_fsm.sv
module vls_loop_fsm #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             all_scalar,
    input  logic [LEN_W-1:0] len_field,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [LEN_W-1:0] elem_o,
    output logic             last_o,
    output logic             accept_o
);
    import vls_pkg::*;

    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] lim_q, lim_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid) begin
                    state_d = S_ISSUE;
                    cnt_d   = '0;
                    lim_d   = all_scalar ? '0 : len_field;
                end
            end
            S_ISSUE: begin
                if (uop_ready) begin
                    if (cnt_q == lim_q) begin
                        state_d = S_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        in_ready  = (state_q == S_IDLE);
        uop_valid = (state_q == S_ISSUE);
        elem_o    = cnt_q;
        last_o    = (state_q == S_ISSUE) && (cnt_q == lim_q);
        accept_o  = (state_q == S_IDLE) && in_valid;
    end

    AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready); // R8
    AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(elem_o))); // R9
    AST_ELEM_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !last_o) |=> (uop_valid && elem_o == $past(elem_o) + 1'b1)); // R7
    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && last_o) |=> !uop_valid); // R7
    AST_RUN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (uop_valid && elem_o == '0)); // R7
endmodule

// File: rtl/vec_loop_sequencer.sv
module vec_loop_sequencer #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic             csr_sel,
    input  logic [LEN_W-1:0] csr_wdata,
    output logic [LEN_W-1:0] csr_rdata,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [6:0]       in_dst,
    input  logic [6:0]       in_src1,
    input  logic [6:0]       in_src2,
    input  logic [2:0]       in_vec,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [6:0]       uop_dst,
    output logic [6:0]       uop_src1,
    output logic [6:0]       uop_src2,
    output logic [LEN_W-1:0] uop_elem,
    output logic             uop_last
);
    import vls_pkg::*;

    logic [LEN_W-1:0]      maxlen, len_field;
    logic                  accept;
    logic [PHYS_REG_W-1:0] base_in [NUM_OPERANDS];
    logic [PHYS_REG_W-1:0] base_q  [NUM_OPERANDS];
    logic [PHYS_REG_W-1:0] idx     [NUM_OPERANDS];
    logic [NUM_OPERANDS-1:0] vec_q;

    assign base_in[0] = in_dst;
    assign base_in[1] = in_src1;
    assign base_in[2] = in_src2;

    vls_len_csr #(.LEN_W(LEN_W)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (csr_we),
        .sel      (csr_sel),
        .wdata    (csr_wdata),
        .rdata    (csr_rdata),
        .maxlen_o (maxlen),
        .len_o    (len_field)
    );

    vls_loop_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .all_scalar (in_vec == '0),
        .len_field  (len_field),
        .uop_valid  (uop_valid),
        .uop_ready  (uop_ready),
        .elem_o     (uop_elem),
        .last_o     (uop_last),
        .accept_o   (accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (accept) begin
            vec_q <= in_vec;
        end
    end

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else if (accept) begin
                base_q[g] <= base_in[g];
            end
        end

        vls_operand_step #(.LEN_W(LEN_W)) u_step (
            .base_i (base_q[g]),
            .vec_i  (vec_q[g]),
            .elem_i (uop_elem),
            .idx_o  (idx[g])
        );
    end

    assign uop_dst  = idx[0];
    assign uop_src1 = idx[1];
    assign uop_src2 = idx[2];

    AST_STALL_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> ($stable(uop_dst) && $stable(uop_src1) && $stable(uop_src2))); // R9
    AST_SCALAR_RUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_vec == 3'b000) |=> (uop_valid && uop_last)); // R6
    AST_LEN_NEVER_OVER_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        len_field <= maxlen); // R1
endmodule

// File: tb/vec_loop_sequencer_test.sv
module vec_loop_sequencer_test;
    localparam int LW = 5;

    typedef struct {
        logic [6:0]    d;
        logic [6:0]    a;
        logic [6:0]    b;
        logic [LW-1:0] e;
        logic          l;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic          csr_sel = 1'b0;
    logic [LW-1:0] csr_wdata = '0;
    logic [LW-1:0] csr_rdata;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [6:0]    in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [2:0]    in_vec = '0;
    logic          uop_valid;
    logic          uop_ready = 1'b1;
    logic [6:0]    uop_dst, uop_src1, uop_src2;
    logic [LW-1:0] uop_elem;
    logic          uop_last;

    int   checks = 0;
    int   errs = 0;
    bit   done = 0;
    bit   stall_en = 0;
    logic [3:0] lfsr = 4'b1001;
    exp_t q[$];
    int   maxf = 0;
    int   lenf = 0;

    logic       pv = 0, pr = 0, pl = 0;
    logic [6:0] pd, pa, pb;
    logic [LW-1:0] pe;

    always #10 clk = ~clk;

    vec_loop_sequencer #(.LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_vec(in_vec),
        .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_dst(uop_dst), .uop_src1(uop_src1), .uop_src2(uop_src2),
        .uop_elem(uop_elem), .uop_last(uop_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
        uop_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pv && !pr) begin
                check(uop_valid && uop_dst == pd && uop_src1 == pa && uop_src2 == pb &&
                      uop_elem == pe && uop_last == pl, "R9 stall hold",
                      int'(uop_elem), int'(pe));
            end
            if (uop_valid) begin
                check(!in_ready, "R8 in_ready low while busy", int'(in_ready), 0);
            end
            if (uop_valid && uop_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected micro-op", int'(uop_elem), -1);
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    check(uop_dst == x.d, {x.tag, " dst"}, int'(uop_dst), int'(x.d));
                    check(uop_src1 == x.a, {x.tag, " src1"}, int'(uop_src1), int'(x.a));
                    check(uop_src2 == x.b, {x.tag, " src2"}, int'(uop_src2), int'(x.b));
                    check(uop_elem == x.e && uop_last == x.l, {x.tag, " elem/last"},
                          int'({uop_elem, uop_last}), int'({x.e, x.l}));
                end
            end
            pv <= uop_valid; pr <= uop_ready; pl <= uop_last;
            pd <= uop_dst; pa <= uop_src1; pb <= uop_src2; pe <= uop_elem;
        end
    end

    task automatic csr_op(input bit we, input bit sel, input int val, input int expv, input string tag);
        csr_we = we; csr_sel = sel; csr_wdata = LW'(val);
        @(posedge clk); #2;
        csr_we = 1'b0;
        @(negedge clk);
        check(csr_rdata == LW'(expv), tag, int'(csr_rdata), expv);
        @(posedge clk); #2;
    endtask

    task automatic wr_max(input int v, input string tag);
        maxf = v;
        if (lenf > maxf) lenf = maxf;
        csr_op(1'b1, 1'b0, v, maxf, tag);
    endtask

    task automatic wr_len(input int v, input string tag);
        lenf = (v > maxf) ? maxf : v;
        csr_op(1'b1, 1'b1, v, lenf, tag);
    endtask

    task automatic issue(input int d, input int a, input int b, input logic [2:0] v, input string tag);
        int n;
        in_dst = 7'(d); in_src1 = 7'(a); in_src2 = 7'(b); in_vec = v; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        n = (v == 3'b000) ? 1 : lenf + 1;
        for (int i = 0; i < n; i++) begin
            exp_t x;
            x.d = 7'((d + (v[0] ? i : 0)) % 128);
            x.a = 7'((a + (v[1] ? i : 0)) % 128);
            x.b = 7'((b + (v[2] ? i : 0)) % 128);
            x.e = LW'(i);
            x.l = (i == n - 1);
            x.tag = tag;
            q.push_back(x);
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R3 in_ready after reset", int'(in_ready), 1);
        check(uop_valid == 1'b0, "R3 uop_valid after reset", int'(uop_valid), 0);
        @(posedge clk); #2;
        csr_op(1'b0, 1'b0, 0, 0, "R3 max field after reset");
        csr_op(1'b0, 1'b1, 0, 0, "R3 len field after reset");
        issue(28, 15, 12, 3'b111, "R3 default length one");
        wait_idle();

        wr_max(7, "R2 max write returns new");
        wr_len(9, "R1 len write clamped to max");
        csr_op(1'b0, 1'b1, 0, 7, "R1 len readback clamped");
        wr_len(3, "R2 len write returns new");
        issue(28, 15, 12, 3'b111, "R4 all vector");
        wait_idle();
        issue(28, 15, 12, 3'b110, "R5 dst scalar");
        wait_idle();
        issue(40, 50, 60, 3'b010, "R5 only src1 vector");
        wait_idle();
        issue(28, 15, 12, 3'b000, "R6 all scalar");
        wait_idle();
        issue(126, 127, 125, 3'b111, "R10 index wrap");
        wait_idle();

        stall_en = 1;
        wr_len(5, "R2 len write returns new");
        issue(10, 20, 30, 3'b101, "R8 first of pair");
        issue(70, 80, 90, 3'b011, "R8 second waits");
        issue(1, 2, 3, 3'b000, "R9 scalar under stall");
        wait_idle();
        stall_en = 0;

        wr_max(1, "R1 max write lowers len");
        csr_op(1'b0, 1'b1, 0, 1, "R1 len lowered to max");
        issue(5, 6, 7, 3'b111, "R7 run of two");
        wait_idle();

        check(q.size() == 0, "R7 scoreboard drained", q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule